// File: doc/BRIEF.md
# Load-Buffer Memory-Order Checker

This block is a runtime monitor for a shared-memory system that follows total store order. It keeps an abstract model of memory built from load buffers: one global value array, and for each processor a private local copy of that array, all indexed by address. A stream of observed memory events is fed to it, one per cycle. Each event is a processor write, a processor read, or a write from an abstract agent such as the shared cache. The block judges whether the value each read returned can be explained by the model.

A read that matches the reading processor's own local entry is accepted at once, even if that value is stale. If it does not match, the checker refreshes that processor's local copy from the whole global array in one step and compares again. The read is accepted if the refreshed entry matches and reported as a violation if it does not. The first violation is latched together with its processor, address and value. Later events are still modelled, so the run goes on from a defined state.

Top module: `lbc_order_checker`

## Requirements
- R1: After reset every global and every local entry holds 0, `err_flag_o` and all result pulses are 0, and a read of value 0 by any processor at any address is accepted without a refresh.
- R2: A processor write (`ev_kind_i` = 0) of value v to address a sets both that processor's local entry for a and the global entry for a to v, in the same step.
- R3: An agent write (`ev_kind_i` = 2) of v to address a sets only the global entry for a. No local entry changes, so a later read of the old local value is still accepted without a refresh.
- R4: A read (`ev_kind_i` = 1) whose value equals the reader's local entry is accepted with `rd_done_o` = 1, `rd_pulled_o` = 0 and `rd_bad_o` = 0.
- R5: A read whose value differs from the reader's local entry copies the entire global array into that processor's local array and is accepted (`rd_pulled_o` = 1, `rd_bad_o` = 0) if the refreshed entry equals the value read.
- R6: A refresh covers every address at once: after it, a read of the current global value of any other address by the same processor is accepted without a further refresh. Local arrays of other processors are not changed by it.
- R7: A read that still does not match after the refresh gives `rd_bad_o` = 1 and sets `err_flag_o`. The flag stays set until reset. `err_proc_o`, `err_addr_o` and `err_data_o` hold the processor, address and value of the first such read, and later violations do not change them.
- R8: A failing read still leaves the refreshed local array in place, so later reads are judged against the refreshed values.
- R9: `ev_ready_o` is 1 whenever `rst` is low and 0 during reset. An event is taken only when `ev_valid_i` and `ev_ready_o` are both 1. `ev_kind_i` = 3 is a no-operation that changes no state and produces no result.
- R10: The result pulses and error fields for an accepted read appear in the cycle after the event is taken. Non-read events and idle cycles produce `rd_done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | Event present |
| ev_ready_o | output | 1 | Checker can take an event |
| ev_kind_i | input | 2 | 0 processor write, 1 read, 2 agent write, 3 no-op |
| ev_proc_i | input | PW | Processor index (ignored for agent writes) |
| ev_addr_i | input | AW | Address |
| ev_data_i | input | VW | Value written or read |
| rd_done_o | output | 1 | A read was judged in the previous cycle |
| rd_pulled_o | output | 1 | That read needed a refresh of the local array |
| rd_bad_o | output | 1 | That read is a violation |
| err_flag_o | output | 1 | Sticky: a violation has been seen |
| err_proc_o | output | PW | Processor of the first violation |
| err_addr_o | output | AW | Address of the first violation |
| err_data_o | output | VW | Value of the first violation |

## Verification
For a read that misses its local entry, the refresh of the whole local array and the second comparison happen in the same cycle. The second comparison has to use the global value being copied, because the updated local entry is not visible until the next edge. The bench provokes this by putting agent writes to several addresses directly in front of reads by one processor, some matching the new global values and some never written. It judges each read by the pulse pattern one cycle later, and judges the copy itself by follow-up reads of other addresses that must then hit without a second refresh.

// File: rtl/lbc_pkg.sv
`timescale 1ns/1ps
package lbc_pkg;
  typedef enum logic [1:0] {
    EV_PWRITE = 2'd0,
    EV_READ   = 2'd1,
    EV_AWRITE = 2'd2,
    EV_NOP    = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/lbc_global_store.sv
`timescale 1ns/1ps
// Global value array: one write port, whole-array snapshot output.
module lbc_global_store #(
  parameter int NADDR = 4,
  parameter int VW    = 4,
  parameter int AW    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [VW-1:0]              wr_data,
  output logic [NADDR-1:0][VW-1:0]   snap
);
  logic [NADDR-1:0][VW-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign snap = mem;
endmodule

// File: rtl/lbc_local_bank.sv
`timescale 1ns/1ps
// Per-processor local arrays with single-entry write and whole-array pull.
module lbc_local_bank #(
  parameter int NPROC = 4,
  parameter int NADDR = 4,
  parameter int VW    = 4,
  parameter int PW    = 2,
  parameter int AW    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [PW-1:0]            wr_proc,
  input  logic [AW-1:0]            wr_addr,
  input  logic [VW-1:0]            wr_data,
  input  logic                     pull_en,
  input  logic [PW-1:0]            pull_proc,
  input  logic [NADDR-1:0][VW-1:0] glob,
  input  logic [PW-1:0]            rd_proc,
  input  logic [AW-1:0]            rd_addr,
  output logic [VW-1:0]            rd_data
);
  logic [NADDR-1:0][VW-1:0] rows [NPROC];

  for (genvar g = 0; g < NPROC; g++) begin : g_proc
    logic [NADDR-1:0][VW-1:0] row;
    logic pull_me, wr_me;
    assign pull_me = pull_en && (pull_proc == PW'(g));
    assign wr_me   = wr_en   && (wr_proc   == PW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        row <= '0;
      end else if (pull_me) begin
        row <= glob;
      end else if (wr_me) begin
        row[wr_addr] <= wr_data;
      end
    end

    assign rows[g] = row;
  end

  assign rd_data = rows[rd_proc][rd_addr];
endmodule

// File: rtl/lbc_judge.sv
`timescale 1ns/1ps
// Two-stage comparison of a read, registered results and sticky first error.
module lbc_judge #(
  parameter int VW = 4,
  parameter int PW = 2,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_read,
  input  logic [PW-1:0] proc,
  input  logic [AW-1:0] addr,
  input  logic [VW-1:0] data,
  input  logic [VW-1:0] local_val,
  input  logic [VW-1:0] global_val,
  output logic          pull_req,
  output logic          rd_done,
  output logic          rd_pulled,
  output logic          rd_bad,
  output logic          err_flag,
  output logic [PW-1:0] err_proc,
  output logic [AW-1:0] err_addr,
  output logic [VW-1:0] err_data
);
  logic local_hit, after_pull_hit, violation;

  assign local_hit      = (local_val == data);
  // After a pull the local entry equals the global one, so compare against it now.
  assign after_pull_hit = (global_val == data);
  assign pull_req       = fire_read && !local_hit;
  assign violation      = pull_req && !after_pull_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done   <= 1'b0;
      rd_pulled <= 1'b0;
      rd_bad    <= 1'b0;
      err_flag  <= 1'b0;
      err_proc  <= '0;
      err_addr  <= '0;
      err_data  <= '0;
    end else begin
      rd_done   <= fire_read;
      rd_pulled <= pull_req;
      rd_bad    <= violation;
      if (violation && !err_flag) begin
        err_flag <= 1'b1;
        err_proc <= proc;
        err_addr <= addr;
        err_data <= data;
      end
    end
  end
endmodule

// File: rtl/lbc_order_checker.sv
`timescale 1ns/1ps
module lbc_order_checker #(
  parameter int NPROC = 4,
  parameter int NADDR = 4,
  parameter int VW    = 4,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NADDR > 1) ? $clog2(NADDR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid_i,
  output logic          ev_ready_o,
  input  logic [1:0]    ev_kind_i,
  input  logic [PW-1:0] ev_proc_i,
  input  logic [AW-1:0] ev_addr_i,
  input  logic [VW-1:0] ev_data_i,
  output logic          rd_done_o,
  output logic          rd_pulled_o,
  output logic          rd_bad_o,
  output logic          err_flag_o,
  output logic [PW-1:0] err_proc_o,
  output logic [AW-1:0] err_addr_o,
  output logic [VW-1:0] err_data_o
);
  import lbc_pkg::*;

  ev_kind_e kind;
  logic fire, fire_pw, fire_aw, fire_rd, glob_we, pull_req;
  logic [NADDR-1:0][VW-1:0] glob;
  logic [VW-1:0] local_val;

  assign ev_ready_o = !rst;
  assign kind    = ev_kind_e'(ev_kind_i);
  assign fire    = ev_valid_i && ev_ready_o;
  assign fire_pw = fire && (kind == EV_PWRITE);
  assign fire_aw = fire && (kind == EV_AWRITE);
  assign fire_rd = fire && (kind == EV_READ);
  assign glob_we = fire_pw || fire_aw;

  lbc_global_store #(.NADDR(NADDR), .VW(VW), .AW(AW)) u_glob (
    .clk(clk), .rst(rst), .wr_en(glob_we), .wr_addr(ev_addr_i),
    .wr_data(ev_data_i), .snap(glob)
  );

  lbc_local_bank #(.NPROC(NPROC), .NADDR(NADDR), .VW(VW), .PW(PW), .AW(AW)) u_loc (
    .clk(clk), .rst(rst), .wr_en(fire_pw), .wr_proc(ev_proc_i),
    .wr_addr(ev_addr_i), .wr_data(ev_data_i), .pull_en(pull_req),
    .pull_proc(ev_proc_i), .glob(glob), .rd_proc(ev_proc_i),
    .rd_addr(ev_addr_i), .rd_data(local_val)
  );

  lbc_judge #(.VW(VW), .PW(PW), .AW(AW)) u_judge (
    .clk(clk), .rst(rst), .fire_read(fire_rd), .proc(ev_proc_i),
    .addr(ev_addr_i), .data(ev_data_i), .local_val(local_val),
    .global_val(glob[ev_addr_i]), .pull_req(pull_req),
    .rd_done(rd_done_o), .rd_pulled(rd_pulled_o), .rd_bad(rd_bad_o),
    .err_flag(err_flag_o), .err_proc(err_proc_o), .err_addr(err_addr_o),
    .err_data(err_data_o)
  );
endmodule

// File: rtl/lbc_order_checker_sva.sv
`timescale 1ns/1ps
module lbc_order_checker_sva #(
  parameter int VW = 4,
  parameter int PW = 2,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_valid_i,
  input logic          ev_ready_o,
  input logic [1:0]    ev_kind_i,
  input logic          rd_done_o,
  input logic          rd_pulled_o,
  input logic          rd_bad_o,
  input logic          err_flag_o,
  input logic [PW-1:0] err_proc_o,
  input logic [AW-1:0] err_addr_o,
  input logic [VW-1:0] err_data_o
);
  p_ready_r9: assert property (@(posedge clk) disable iff (rst) ev_ready_o);

  p_read_result_r10: assert property (@(posedge clk) disable iff (rst)
    (ev_valid_i && ev_ready_o && ev_kind_i == 2'd1) |=> rd_done_o);

  p_no_result_r10: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid_i && ev_ready_o && ev_kind_i == 2'd1) |=> !rd_done_o);

  p_nop_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_valid_i && ev_kind_i == 2'd3) |=> !rd_done_o);

  p_pull_in_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_pulled_o |-> rd_done_o);

  p_bad_after_pull_r7: assert property (@(posedge clk) disable iff (rst)
    rd_bad_o |-> (rd_pulled_o && err_flag_o));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag_o |=> err_flag_o);

  p_first_kept_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag_o |=> ($stable(err_proc_o) && $stable(err_addr_o) && $stable(err_data_o)));
endmodule

bind lbc_order_checker lbc_order_checker_sva #(.VW(VW), .PW(PW), .AW(AW)) u_sva (
  .clk(clk), .rst(rst), .ev_valid_i(ev_valid_i), .ev_ready_o(ev_ready_o),
  .ev_kind_i(ev_kind_i), .rd_done_o(rd_done_o), .rd_pulled_o(rd_pulled_o),
  .rd_bad_o(rd_bad_o), .err_flag_o(err_flag_o), .err_proc_o(err_proc_o),
  .err_addr_o(err_addr_o), .err_data_o(err_data_o)
);

// File: tb/sim_lbc_order_checker.sv
`timescale 1ns/1ps
module sim_lbc_order_checker;
  localparam int NP = 4;
  localparam int NA = 4;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid_i = 1'b0;
  logic ev_ready_o;
  logic [1:0] ev_kind_i = 2'd0;
  logic [1:0] ev_proc_i = '0;
  logic [1:0] ev_addr_i = '0;
  logic [VW-1:0] ev_data_i = '0;
  logic rd_done_o, rd_pulled_o, rd_bad_o, err_flag_o;
  logic [1:0] err_proc_o, err_addr_o;
  logic [VW-1:0] err_data_o;

  lbc_order_checker #(.NPROC(NP), .NADDR(NA), .VW(VW)) u0 (
    .clk(clk), .rst(rst), .ev_valid_i(ev_valid_i), .ev_ready_o(ev_ready_o),
    .ev_kind_i(ev_kind_i), .ev_proc_i(ev_proc_i), .ev_addr_i(ev_addr_i),
    .ev_data_i(ev_data_i), .rd_done_o(rd_done_o), .rd_pulled_o(rd_pulled_o),
    .rd_bad_o(rd_bad_o), .err_flag_o(err_flag_o), .err_proc_o(err_proc_o),
    .err_addr_o(err_addr_o), .err_data_o(err_data_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference: plain integer arrays.
  int gm [NA];
  int lm [NP][NA];
  bit x_done, x_pull, x_bad, x_flag;
  int x_p, x_a, x_v;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, {29'd0, rd_done_o, rd_pulled_o, rd_bad_o}, {29'd0, x_done, x_pull, x_bad}, "done/pull/bad");
    check(tag, int'(err_flag_o), int'(x_flag), "err_flag");
    if (x_flag) begin
      check(tag, int'(err_proc_o), x_p, "err_proc");
      check(tag, int'(err_addr_o), x_a, "err_addr");
      check(tag, int'(err_data_o), x_v, "err_data");
    end
  endtask

  task automatic model(input int k, input int p, input int a, input int v);
    x_done = 0; x_pull = 0; x_bad = 0;
    if (k == 0) begin
      gm[a] = v; lm[p][a] = v;
    end else if (k == 2) begin
      gm[a] = v;
    end else if (k == 1) begin
      x_done = 1;
      if (lm[p][a] != v) begin
        x_pull = 1;
        for (int i = 0; i < NA; i++) lm[p][i] = gm[i];
        if (lm[p][a] != v) begin
          x_bad = 1;
          if (!x_flag) begin
            x_flag = 1; x_p = p; x_a = a; x_v = v;
          end
        end
      end
    end
  endtask

  // Called at a negative edge; checks one cycle later at the next negative edge.
  task automatic ev(input int k, input int p, input int a, input int v, input string tag);
    model(k, p, a, v);
    ev_valid_i = 1'b1;
    ev_kind_i  = 2'(k);
    ev_proc_i  = 2'(p);
    ev_addr_i  = 2'(a);
    ev_data_i  = VW'(v);
    @(posedge clk);
    @(negedge clk);
    ev_valid_i = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    ev_valid_i = 1'b0;
    ev_kind_i  = 2'd1;
    ev_data_i  = VW'(15);
    for (int i = 0; i < n; i++) begin
      x_done = 0; x_pull = 0; x_bad = 0;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NA; a++) begin
      gm[a] = 0;
      for (int p = 0; p < NP; p++) lm[p][a] = 0;
    end
    x_flag = 0; x_p = 0; x_a = 0; x_v = 0;
    x_done = 0; x_pull = 0; x_bad = 0;
    repeat (4) @(negedge clk);
    check("R9", int'(ev_ready_o), 0, "ready in reset");
    rst = 1'b0;
    #0.1;
    check("R9", int'(ev_ready_o), 1, "ready after reset");
    compare("R1 reset state");

    // R1: everything starts at zero, reads of 0 hit.
    for (int p = 0; p < NP; p++) ev(1, p, p, 0, "R1 zero read hits");

    // R2: processor write updates own local and global.
    ev(0, 1, 2, 5, "R2 write");
    ev(1, 1, 2, 5, "R2 own read hits");
    ev(1, 0, 2, 5, "R2 other read pulls");
    ev(1, 2, 2, 0, "R2 stale read allowed");

    // R3: agent write touches only global.
    ev(2, 3, 3, 9, "R3 agent write");
    ev(1, 1, 3, 0, "R3 stale read hits");
    ev(1, 1, 3, 9, "R3 new value pulls");

    // R5/R6: one pull covers all addresses; other processors untouched.
    ev(2, 0, 0, 7, "R6 agent write a0");
    ev(2, 0, 1, 8, "R6 agent write a1");
    ev(1, 3, 0, 7, "R5 read pulls");
    ev(1, 3, 1, 8, "R6 other address hits");
    ev(1, 3, 2, 5, "R6 third address hits");
    ev(1, 2, 1, 0, "R6 other proc untouched");
    ev(1, 3, 0, 7, "R4 repeat read hits");

    // R9: no-op kind and invalid cycles change nothing.
    ev(3, 2, 1, 8, "R9 nop kind");
    ev(1, 2, 1, 0, "R9 nop left state");
    idle(3, "R9 idle no result");
    ev(1, 2, 0, 0, "R9 idle left state");

    // R7: value never written.
    ev(1, 0, 1, 12, "R7 bad read");
    idle(2, "R7 flag sticky");
    // R8: failed read still pulled.
    ev(1, 0, 1, 8, "R8 pulled state after fail");
    ev(1, 0, 0, 7, "R8 pulled other address");
    // R7: second violation keeps first record.
    ev(1, 2, 0, 13, "R7 second bad read");
    ev(0, 2, 0, 13, "R10 write after bad");
    ev(1, 2, 0, 13, "R2 own write hits");
    ev(1, 1, 0, 13, "R3 proc write seen after pull");

    // Back-to-back mix (R10).
    for (int i = 0; i < 8; i++) begin
      ev(2, 0, i % NA, (i * 3) % 16, "R10 mix agent");
      ev(1, i % NP, i % NA, (i * 3) % 16, "R10 mix read");
      ev(1, (i + 1) % NP, (i + 2) % NA, (i * 5) % 16, "R10 mix read2");
    end
    idle(2, "R10 tail idle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule